// File: doc/BRIEF.md
# Addressed Radio Packet Receiver

This block sits behind the sync-word detector of a low-rate packet radio. Once the sync word has matched, the receive FIFO presents one byte per `rx_valid` strobe. The block lays each packet out in a small on-chip buffer: group code in slot 0, header in slot 1, length in slot 2, and payload from slot 3 onward. It keeps a CRC-16 running as the bytes arrive and uses the packet's own length byte to decide when the packet has ended. When the packet is complete, the block asks the radio to go idle and then checks whether the packet is meant for this node.

A packet that passes the address check is held in the buffer until `restart` is pulsed, and `pkt_ready` is raised for one cycle. While the packet is held, the block presents the CRC verdict, the header and the length, and the buffer can be read through `rd_addr`/`rd_data`. It also reports whether the packet asks for an acknowledgement and gives the header byte to use for that acknowledgement. A packet that fails the address check is discarded without notice, and the block begins receiving the next packet at once. After reset the block ignores incoming bytes until the first `restart`.

Header byte layout: bit 7 marks a control (acknowledgement) packet, bit 6 says that bits 4:0 name the destination (when it is clear, bits 4:0 name the source), bit 5 requests an acknowledgement, and bits 4:0 carry a node number.

Top module: `pkt_rx_filter`

## Requirements
- R1: After reset, `pkt_ready`, `rx_idle_req`, `crc_ok`, `want_ack`, `hdr_out`, `len_out` and `ack_hdr` are 0. Every buffer slot reads 0. Bytes offered before the first `restart` are not stored.
- R2: When `restart` is pulsed with a nonzero `group_id`, the group value is written to slot 0, and received bytes fill slots 1, 2, 3 and onward in arrival order. When `group_id` is zero, the first received byte goes to slot 0. Slot 1 is always the header and slot 2 is always the length.
- R3: A packet completes on the accepted byte that brings the stored count (group slot included) to the length byte plus 5. `pkt_ready` and `rx_idle_req` are then both high for exactly the one cycle after that clock edge.
- R4: A packet also completes when the stored count reaches 71, whatever the length byte says. Such a packet therefore holds 70 received bytes when the group is nonzero.
- R5: The CRC uses the reflected polynomial 0xA001 and a 0xFFFF preset. It is first seeded with a nonzero group, then updated with every received byte, the two trailing CRC bytes included (low byte first). `crc_ok` is 1 only when the final value is zero.
- R6: A length byte above 66 forces `crc_ok` to 0.
- R7: A completed packet is delivered when header bit 6 is clear, when `node_id` is 31, or when header bits 4:0 equal `node_id`. Otherwise `pkt_ready` stays low, `rx_idle_req` still pulses, and reception restarts by itself without a `restart` pulse.
- R8: `want_ack` is 1 for a held packet whose header bit 5 is set and bit 7 is clear.
- R9: `ack_hdr` is 0x80 when the held header had bit 6 set. Otherwise it is 0xC0 OR'd with the held header bits 4:0.
- R10: Bytes offered while a packet is held are ignored. Buffer contents and all outputs stay unchanged.
- R11: `hdr_out`, `len_out`, `crc_ok`, `want_ack` and `ack_hdr` stay stable from delivery until `restart`. They read 0 whenever no packet is held.
- R12: A `restart` during reception discards the partial packet. The next packet is received from a clean fill count and CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| group_id | input | 8 | Network group code; zero means single-byte sync |
| node_id | input | 5 | This node's number; 31 accepts all |
| restart | input | 1 | Begin a fresh reception, discarding any held or partial packet |
| rx_valid | input | 1 | Byte strobe from the receive FIFO |
| rx_byte | input | 8 | Received byte |
| rd_addr | input | 7 | Buffer read slot |
| rd_data | output | 8 | Buffer contents at `rd_addr` (0 beyond slot 70) |
| pkt_ready | output | 1 | One-cycle strobe: a packet was delivered |
| rx_idle_req | output | 1 | One-cycle request to put the radio receiver in idle |
| crc_ok | output | 1 | Held packet passed CRC and length checks |
| hdr_out | output | 8 | Held packet header |
| len_out | output | 8 | Held packet length byte |
| want_ack | output | 1 | Held packet requests an acknowledgement |
| ack_hdr | output | 8 | Header byte for the acknowledgement reply |

## Verification
The in-RTL assertions check on every cycle that the ready strobe lasts one cycle and always comes with an idle request, and that the fill count never passes the buffer size. They also check that a held packet's fill, CRC and reported fields stay frozen until restart, and that an over-long length never reports a good CRC. Whether the correct packets are delivered or dropped, the CRC arithmetic itself, the slot layout with and without a group code, and the exact completion cycle can only be shown by the bench's scenarios, which drive a behavioural model alongside the design.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;
    localparam int ID_W   = 5;

    localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'hA001;

    // header bit positions
    localparam int HB_CTL = 7;
    localparam int HB_DST = 6;
    localparam int HB_ACK = 5;

    typedef enum logic [1:0] {
        RX_OFF  = 2'd0,
        RX_FILL = 2'd1,
        RX_HOLD = 2'd2
    } rx_mode_e;

endpackage

// File: rtl/pkt_crc16_byte.sv
module pkt_crc16_byte
    import pkt_rx_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    logic [CRC_W-1:0] acc;

    // LSB-first shift of one byte through the reflected polynomial
    always_comb begin
        acc = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, data_in};
        for (int i = 0; i < BYTE_W; i++) begin
            acc = acc[0] ? ((acc >> 1) ^ POLY) : (acc >> 1);
        end
        crc_out = acc;
    end

endmodule

// File: rtl/pkt_addr_match.sv
module pkt_addr_match
    import pkt_rx_pkg::*;
#(
    parameter int ALL_ID = 31
) (
    input  logic [BYTE_W-1:0] hdr,
    input  logic [ID_W-1:0]   node_id,
    output logic              accept,
    output logic              want_ack,
    output logic [BYTE_W-1:0] ack_hdr
);

    logic [ID_W-1:0] hdr_id;
    logic            is_directed;

    assign hdr_id      = hdr[ID_W-1:0];
    assign is_directed = hdr[HB_DST];

    always_comb begin
        accept = !is_directed
              || (node_id == ID_W'(ALL_ID))
              || (hdr_id == node_id);

        want_ack = hdr[HB_ACK] && !hdr[HB_CTL];

        ack_hdr = '0;
        ack_hdr[HB_CTL] = 1'b1;
        if (!is_directed) begin
            ack_hdr[HB_DST]      = 1'b1;
            ack_hdr[ID_W-1:0]    = hdr_id;
        end
    end

endmodule

// File: rtl/pkt_buffer.sv
module pkt_buffer #(
    parameter int W     = 8,
    parameter int DEPTH = 71,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          seed_en,
    input  logic [W-1:0]  seed_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] slot_view [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [W-1:0] val_q;
        logic [W-1:0] val_d;

        if (g == 0) begin : g_seeded
            always_comb begin
                val_d = val_q;
                if (seed_en) begin
                    val_d = seed_data;
                end else if (wr_en && wr_addr == AW'(g)) begin
                    val_d = wr_data;
                end
            end
        end else begin : g_plain
            always_comb begin
                val_d = val_q;
                if (wr_en && wr_addr == AW'(g)) begin
                    val_d = wr_data;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else begin
                val_q <= val_d;
            end
        end

        assign slot_view[g] = val_q;
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < DEPTH) begin
            rd_data = slot_view[rd_addr];
        end
    end

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH)); // R4

endmodule

// File: rtl/pkt_rx_filter.sv
module pkt_rx_filter
    import pkt_rx_pkg::*;
#(
    parameter int DEPTH       = 71,
    parameter int MAX_PAYLOAD = 66,
    parameter int FRAME_EXTRA = 5,
    parameter int ALL_ID      = 31,
    parameter int ADDR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] group_id,
    input  logic [ID_W-1:0]   node_id,
    input  logic              restart,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              pkt_ready,
    output logic              rx_idle_req,
    output logic              crc_ok,
    output logic [BYTE_W-1:0] hdr_out,
    output logic [BYTE_W-1:0] len_out,
    output logic              want_ack,
    output logic [BYTE_W-1:0] ack_hdr
);

    localparam int FILL_W   = $clog2(DEPTH + 1);
    localparam int SUM_W    = BYTE_W + 1;
    localparam int HDR_SLOT = 1;
    localparam int LEN_SLOT = 2;

    typedef struct packed {
        rx_mode_e            st;
        logic [FILL_W-1:0]   fill;
        logic [CRC_W-1:0]    crc;
        logic [BYTE_W-1:0]   hdr;
        logic [BYTE_W-1:0]   len;
        logic                ok;
        logic                ready;
        logic                idle;
    } rx_regs_t;

    rx_regs_t r_q, r_d, start_r;

    logic                grp_nz;
    logic [CRC_W-1:0]    crc_seed, crc_next;
    logic [BYTE_W-1:0]   hdr_eff, len_eff;
    logic [FILL_W-1:0]   fill_inc;
    logic [SUM_W-1:0]    frame_end;
    logic                reached;
    logic                hit_accept, hit_want_unused;
    logic [BYTE_W-1:0]   hit_ack_unused;
    logic                hold_accept_unused, hold_want;
    logic [BYTE_W-1:0]   hold_ack;
    logic                wr_en, seed_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic                holding;

    assign grp_nz = |group_id;

    // CRC preset seeded with the group code
    pkt_crc16_byte u_crc_seed (
        .crc_in  (CRC_INIT),
        .data_in (group_id),
        .crc_out (crc_seed)
    );

    // running CRC step for the incoming byte
    pkt_crc16_byte u_crc_run (
        .crc_in  (r_q.crc),
        .data_in (rx_byte),
        .crc_out (crc_next)
    );

    // address decision on the header as it stands after this byte
    pkt_addr_match #(.ALL_ID(ALL_ID)) u_match_live (
        .hdr      (hdr_eff),
        .node_id  (node_id),
        .accept   (hit_accept),
        .want_ack (hit_want_unused),
        .ack_hdr  (hit_ack_unused)
    );

    // acknowledgement fields for the held header
    pkt_addr_match #(.ALL_ID(ALL_ID)) u_match_hold (
        .hdr      (r_q.hdr),
        .node_id  (node_id),
        .accept   (hold_accept_unused),
        .want_ack (hold_want),
        .ack_hdr  (hold_ack)
    );

    pkt_buffer #(.W(BYTE_W), .DEPTH(DEPTH), .AW(ADDR_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (rx_byte),
        .seed_en   (seed_en),
        .seed_data (group_id),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    always_comb begin
        hdr_eff   = (r_q.fill == FILL_W'(HDR_SLOT)) ? rx_byte : r_q.hdr;
        len_eff   = (r_q.fill == FILL_W'(LEN_SLOT)) ? rx_byte : r_q.len;
        fill_inc  = r_q.fill + 1'b1;
        frame_end = {1'b0, len_eff} + SUM_W'(FRAME_EXTRA);
        reached   = (SUM_W'(fill_inc) >= frame_end)
                 || (fill_inc >= FILL_W'(DEPTH));

        start_r      = '0;
        start_r.st   = RX_FILL;
        start_r.fill = grp_nz ? FILL_W'(1) : '0;
        start_r.crc  = grp_nz ? crc_seed : CRC_INIT;

        r_d       = r_q;
        r_d.ready = 1'b0;
        r_d.idle  = 1'b0;
        wr_en     = 1'b0;
        seed_en   = 1'b0;
        wr_addr   = ADDR_W'(r_q.fill);

        if (restart) begin
            r_d     = start_r;
            seed_en = grp_nz;
        end else if (r_q.st == RX_FILL && rx_valid) begin
            wr_en    = 1'b1;
            r_d.fill = fill_inc;
            r_d.crc  = crc_next;
            r_d.hdr  = hdr_eff;
            r_d.len  = len_eff;
            if (reached) begin
                if (hit_accept) begin
                    r_d.st    = RX_HOLD;
                    r_d.ready = 1'b1;
                    r_d.ok    = (crc_next == '0)
                             && (len_eff <= BYTE_W'(MAX_PAYLOAD));
                end else begin
                    r_d     = start_r;
                    seed_en = grp_nz;
                end
                r_d.idle = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign holding     = (r_q.st == RX_HOLD);
    assign pkt_ready   = r_q.ready;
    assign rx_idle_req = r_q.idle;
    assign crc_ok      = holding && r_q.ok;
    assign hdr_out     = holding ? r_q.hdr : '0;
    assign len_out     = holding ? r_q.len : '0;
    assign want_ack    = holding && hold_want;
    assign ack_hdr     = holding ? hold_ack : '0;

    AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RX_OFF) |-> (!pkt_ready && !rx_idle_req && r_q.fill == '0)); // R1

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |=> !pkt_ready); // R3

    AST_READY_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (rx_idle_req && holding)); // R3

    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.fill <= FILL_W'(DEPTH)); // R4

    AST_LONG_LEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready && len_out > BYTE_W'(MAX_PAYLOAD)) |-> !crc_ok); // R6

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && !restart) |=> ($stable(r_q.fill) && $stable(r_q.crc))); // R10

    AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && !restart) |=> ($stable(hdr_out) && $stable(len_out)
                                   && $stable(crc_ok) && $stable(ack_hdr))); // R11

    AST_ACK_IS_CONTROL: assert property (@(posedge clk) disable iff (!rst_n)
        holding |-> (ack_hdr[HB_CTL] && !ack_hdr[HB_ACK])); // R9

endmodule

// File: tb/pkt_rx_filter_bench.sv
module pkt_rx_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;
    localparam int NSLOT      = 71;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] group_id;
    logic [4:0] node_id;
    logic       restart;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic [6:0] rd_addr;
    logic [7:0] rd_data;
    logic       pkt_ready, rx_idle_req, crc_ok, want_ack;
    logic [7:0] hdr_out, len_out, ack_hdr;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_rx_filter u_pkt_rx_filter (
        .clk(clk), .rst_n(rst_n), .group_id(group_id), .node_id(node_id),
        .restart(restart), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_addr(rd_addr), .rd_data(rd_data), .pkt_ready(pkt_ready),
        .rx_idle_req(rx_idle_req), .crc_ok(crc_ok), .hdr_out(hdr_out),
        .len_out(len_out), .want_ack(want_ack), .ack_hdr(ack_hdr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural model
    logic [7:0]  mbuf [NSLOT];
    int          mstate;   // 0 off, 1 receiving, 2 holding
    int          mfill;
    logic [15:0] mcrc;
    logic [7:0]  mhdr, mlen;
    bit          mok;
    bit          e_ready, e_idle;

    int ready_cnt = 0;
    int idle_cnt  = 0;
    int bytes_sent = 0;
    int bytes_at_ready = 0;
    int sweep = 0;
    logic [7:0] pq [$];

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] b);
        logic [15:0] x;
        x = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ 16'hA001) : (x >> 1);
        return x;
    endfunction

    task automatic model_restart();
        mstate = 1; mhdr = 0; mlen = 0; mok = 0;
        if (group_id != 0) begin
            mbuf[0] = group_id; mfill = 1; mcrc = crc_step(16'hFFFF, group_id);
        end else begin
            mfill = 0; mcrc = 16'hFFFF;
        end
    endtask

    task automatic model_step();
        e_ready = 0; e_idle = 0;
        if (restart) model_restart();
        else if (mstate == 1 && rx_valid) begin
            mbuf[mfill] = rx_byte;
            mcrc = crc_step(mcrc, rx_byte);
            if (mfill == 1) mhdr = rx_byte;
            if (mfill == 2) mlen = rx_byte;
            mfill++;
            if (mfill >= int'(mlen) + 5 || mfill >= NSLOT) begin
                e_idle = 1;
                if (!mhdr[6] || node_id == 5'd31 || mhdr[4:0] == node_id) begin
                    mstate = 2; e_ready = 1;
                    mok = (mcrc == 0) && (mlen <= 66);
                end else model_restart();
            end
        end
    endtask

    task automatic compare();
        bit held;
        int exp_rd;
        held = (mstate == 2);
        check("R3 pkt_ready", pkt_ready, e_ready);
        check("R3 rx_idle_req", rx_idle_req, e_idle);
        check("R5 crc_ok", crc_ok, held && mok);
        check("R11 hdr_out", hdr_out, held ? mhdr : 0);
        check("R11 len_out", len_out, held ? mlen : 0);
        check("R8 want_ack", want_ack, held && mhdr[5] && !mhdr[7]);
        check("R9 ack_hdr", ack_hdr,
              !held ? 0 : (mhdr[6] ? 8'h80 : (8'hC0 | {3'b0, mhdr[4:0]})));
        exp_rd = (int'(rd_addr) < NSLOT) ? mbuf[rd_addr] : 0;
        check("R2 rd_data", rd_data, exp_rd);
        if (pkt_ready) begin ready_cnt++; bytes_at_ready = bytes_sent; end
        if (rx_idle_req) idle_cnt++;
    endtask

    task automatic cyc(bit rs, bit v, logic [7:0] b);
        restart = rs; rx_valid = v; rx_byte = b;
        sweep = (sweep + 1) % 72;
        rd_addr = 7'(sweep);
        model_step();
        if (v && !rs) bytes_sent++;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic peek(int addr, int exp, string req);
        rd_addr = 7'(addr);
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic build(bit with_grp, logic [7:0] txg, logic [7:0] hdr,
                         int len, int ndata, bit corrupt);
        logic [15:0] c;
        logic [7:0] d;
        pq.delete();
        c = crc_step(16'hFFFF, txg);
        if (with_grp) pq.push_back(txg);
        pq.push_back(hdr); c = crc_step(c, hdr);
        pq.push_back(8'(len)); c = crc_step(c, 8'(len));
        for (int i = 0; i < ndata; i++) begin
            d = 8'((i * 37 + int'(hdr)) & 255);
            pq.push_back(d); c = crc_step(c, d);
        end
        pq.push_back(c[7:0] ^ {7'b0, corrupt});
        pq.push_back(c[15:8]);
    endtask

    task automatic send();
        bytes_sent = 0;
        foreach (pq[i]) begin
            cyc(0, 1, pq[i]);
            if (i % 3 == 2) cyc(0, 0, 8'h00);
        end
        cyc(0, 0, 8'h00);
    endtask

    initial begin
        int rc, keep;
        rst_n = 0; group_id = 8'hD4; node_id = 5'd5;
        restart = 0; rx_valid = 0; rx_byte = 0; rd_addr = 0;
        for (int i = 0; i < NSLOT; i++) mbuf[i] = 0;
        mstate = 0; mfill = 0; mcrc = 0; mhdr = 0; mlen = 0; mok = 0;
        e_ready = 0; e_idle = 0;
        repeat (3) @(negedge clk);
        check("R1 reset pkt_ready", pkt_ready, 0);
        check("R1 reset hdr_out", hdr_out, 0);
        check("R1 reset ack_hdr", ack_hdr, 0);
        rst_n = 1;
        @(negedge clk);
        // bytes before any restart are not stored
        for (int i = 0; i < 4; i++) cyc(0, 1, 8'(8'h30 + i));
        peek(0, 0, "R1 slot0 untouched");
        peek(1, 0, "R1 slot1 untouched");

        // broadcast packet, good CRC
        cyc(1, 0, 0);
        build(0, 8'hD4, 8'h03, 4, 4, 0); send();
        check("R3 one delivery", ready_cnt, 1);
        check("R3 completion byte count", bytes_at_ready, 8);
        check("R5 good crc", crc_ok, 1);
        peek(0, 8'hD4, "R2 group slot");
        peek(1, 8'h03, "R2 header slot");
        peek(2, 8'h04, "R2 length slot");

        // bytes while holding are ignored
        rd_addr = 3; #1; keep = rd_data;
        for (int i = 0; i < 3; i++) cyc(0, 1, 8'hEE);
        peek(3, keep, "R10 slot3 unchanged");
        peek(4, mbuf[4], "R10 slot4 unchanged");
        check("R10 hdr unchanged", hdr_out, 8'h03);
        check("R10 no extra ready", ready_cnt, 1);

        // directed to us, ack wanted
        cyc(1, 0, 0);
        check("R11 cleared by restart", hdr_out, 0);
        build(0, 8'hD4, 8'h65, 2, 2, 0); send();
        check("R8 wants ack", want_ack, 1);
        check("R9 ack hdr directed", ack_hdr, 8'h80);

        // broadcast from node 9, ack wanted
        cyc(1, 0, 0);
        build(0, 8'hD4, 8'h29, 1, 1, 0); send();
        check("R9 ack hdr to source", ack_hdr, 8'hC9);

        // control packet never wants ack
        cyc(1, 0, 0);
        build(0, 8'hD4, 8'hA5, 1, 1, 0); send();
        check("R8 control no ack", want_ack, 0);

        // directed to another node: dropped, auto restart
        cyc(1, 0, 0);
        rc = ready_cnt; keep = idle_cnt;
        build(0, 8'hD4, 8'h47, 1, 1, 0); send();
        check("R7 dropped no ready", ready_cnt, rc);
        check("R7 dropped idle req", idle_cnt, keep + 1);
        check("R7 slot0 regrouped", mbuf[0], 8'hD4);
        build(0, 8'hD4, 8'h45, 1, 1, 0); send();
        check("R7 next packet after drop", ready_cnt, rc + 1);
        check("R7 next packet crc", crc_ok, 1);

        // catch-all node id
        node_id = 5'd31;
        cyc(1, 0, 0);
        rc = ready_cnt;
        build(0, 8'hD4, 8'h47, 3, 3, 0); send();
        check("R7 node 31 accepts", ready_cnt, rc + 1);
        node_id = 5'd5;

        // corrupted CRC
        cyc(1, 0, 0);
        build(0, 8'hD4, 8'h05, 6, 6, 1); send();
        check("R5 bad crc flagged", crc_ok, 0);
        check("R5 bad crc still delivered", hdr_out, 8'h05);

        // length beyond limit: capped completion
        cyc(1, 0, 0);
        build(0, 8'hD4, 8'h01, 70, 72, 0); send();
        check("R4 capped byte count", bytes_at_ready, 70);
        check("R4 length reported", len_out, 70);
        check("R6 long length bad", crc_ok, 0);

        // zero group: group byte arrives in the stream
        group_id = 8'h00;
        cyc(1, 0, 0);
        build(1, 8'hD4, 8'h03, 3, 3, 0); send();
        peek(0, 8'hD4, "R2 zero group slot0");
        peek(1, 8'h03, "R2 zero group header");
        check("R5 zero group crc", crc_ok, 1);

        // restart in the middle of a packet
        group_id = 8'h2B;
        cyc(1, 0, 0);
        cyc(0, 1, 8'h03); cyc(0, 1, 8'd10); cyc(0, 1, 8'h11);
        cyc(1, 0, 0);
        rc = ready_cnt;
        build(0, 8'h2B, 8'h04, 2, 2, 0); send();
        check("R12 clean packet after abort", ready_cnt, rc + 1);
        check("R12 crc after abort", crc_ok, 1);
        check("R12 length after abort", len_out, 2);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule